// File: doc/BRIEF.md
# Startup Configuration Capture Latch

This block captures a 16-bit startup configuration word from the port pins at the end of each reset. It then holds that word as the chip's configuration register. While reset is in progress it decides, pin group by pin group, whether core logic sees the live pin level or the previously held value. As a result, slow-settling pull resistors and noise cannot cause a false mode entry. The pin view stays masked for an initial settle window and then opens for the upper pins. The two lowest pins, which select adapt mode and emulation mode, stay masked until the capture point itself.

A reset sequencer tells the block when a reset starts, which kind of reset it is, and whether the external reset input is still asserted. Capture is timed from the later of two events: the end of the internal sequence window, or the release of the external reset input. It then waits a clock-mode dependent delay. A software or watchdog reset does not refresh the two mode-select bits unless bidirectional reset is enabled. When the single-chip input is high, the pins are ignored and a fixed safe word is loaded instead. Software may overwrite that word exactly once.

Top module: `startup_cfg_latch`

## Requirements
- R1: After the synchronous reset `rst`, `cfg_o` is 0, `cfg_valid_o` is 0 and `pin_view_o` is 0.
- R2: The capture lands `DLY_PRESC` (7) clock edges after the trigger edge when `clk_mode_i` = 0, and `DLY_DIRECT` (10) edges after it when `clk_mode_i` = 1. The trigger edge is the first edge at which the window has elapsed and `ext_rst_i` is low.
- R3: If `ext_rst_i` is released before the window ends (short reset), the trigger is the window end. If it is released after the window ends (long reset), the trigger is its release.
- R4: During reset, `pin_view_o[15:2]` shows the held `cfg_o[15:2]` for the first `SEQ_TCL` cycles, or for `2*SEQ_TCL` cycles when `rst_kind_i` = 0 (power-on). After that it follows the pins until capture. Outside reset, `pin_view_o` follows the pins. The view is registered, so it lags the pins by one cycle.
- R5: During reset, `pin_view_o[1:0]` shows the held `cfg_o[1:0]` until the capture point.
- R6: A pin capture loads `cfg_o` from `pin_i`. The field outputs decode it as follows: [15:13] clock configuration, [12:11] segment address lines, [10:9] chip-select count, [8] write configuration, [7:6] bus type, [5:2] startup mode, [1] adapt mode and [0] emulation mode.
- R7: For `rst_kind_i` 3 (software) or 4 (watchdog) with `bidir_en_i` = 0 at reset start, bits [1:0] keep their previous value. With `bidir_en_i` = 1 they are captured from the pins.
- R8: If `single_chip_i` is high at the capture edge, the pins are ignored and `cfg_o` becomes `DEFAULT_CFG` with bits [1:0] forced to 0.
- R9: After a single-chip capture, the first `cfg_we_i` outside reset replaces `cfg_o` with `cfg_wdata_i`, forcing bits [1:0] to 0. Every further write is ignored: a second write, a write after a pin capture, and a write during reset.
- R10: `cfg_valid_o` is high for exactly one cycle, just after each capture.
- R11: A new `rst_start_i` pulse during a reset restarts the window, and capture timing counts from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per timing unit |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 16 | Port pin levels |
| ext_rst_i | input | 1 | External reset input asserted (active high) |
| rst_start_i | input | 1 | One-cycle pulse when a reset begins |
| rst_kind_i | input | 3 | 0 power-on, 1 long hw, 2 short hw, 3 software, 4 watchdog |
| bidir_en_i | input | 1 | Bidirectional reset enabled |
| clk_mode_i | input | 1 | 0 prescaler, 1 direct drive or PLL |
| single_chip_i | input | 1 | Single-chip mode select |
| cfg_we_i | input | 1 | Software write strobe |
| cfg_wdata_i | input | 16 | Software write data |
| cfg_o | output | 16 | Configuration word |
| clk_cfg_o | output | 3 | Clock configuration field |
| seg_lines_o | output | 2 | Segment address line field |
| cs_count_o | output | 2 | Chip-select count field |
| wr_cfg_o | output | 1 | Write configuration field |
| bus_type_o | output | 2 | Bus type field |
| boot_mode_o | output | 4 | Startup mode field |
| adapt_o | output | 1 | Adapt mode select |
| emu_o | output | 1 | Emulation mode select |
| cfg_valid_o | output | 1 | One-cycle capture pulse |
| pin_view_o | output | 16 | Masked pin view seen by core logic |

## Verification
The bench runs a behavioural model and compares `cfg_o`, `cfg_valid_o` and `pin_view_o` on every cycle. This comparison exposes a wrong window counter or kind register at once.

- A wrong window length makes `pin_view_o` open a cycle early or late.
- A wrong delay count makes `cfg_valid_o` miss its exact cycle.
- A lost lock or keep flag appears in `cfg_o` on the very next capture or write.

Explicit checks fix the capture cycle for both clock modes, for short and long resets and for a restarted reset.

// File: rtl/stcap_pkg.sv
package stcap_pkg;

  localparam int CFG_W = 16;
  localparam int LOW_W = 2;

  typedef enum logic [2:0] {
    RK_POWER_ON = 3'd0,
    RK_HW_LONG  = 3'd1,
    RK_HW_SHORT = 3'd2,
    RK_SOFT     = 3'd3,
    RK_WDOG     = 3'd4
  } rst_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_DELAY = 2'd2
  } phase_e;

  typedef struct packed {
    logic [2:0] clk_cfg;
    logic [1:0] seg;
    logic [1:0] cs;
    logic       wr_cfg;
    logic [1:0] bus;
    logic [3:0] boot;
    logic       adapt;
    logic       emu;
  } cfg_t;

endpackage

// File: rtl/stcap_timer.sv
module stcap_timer
  import stcap_pkg::*;
#(
  parameter int SEQ_TCL    = 1024,
  parameter int DLY_PRESC  = 7,
  parameter int DLY_DIRECT = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [2:0] kind_i,
  input  logic       clk_mode_i,
  input  logic       bidir_i,
  input  logic       ext_rst_i,
  output logic       in_reset_o,
  output logic       hi_open_o,
  output logic       cap_o,
  output logic       keep_low_o
);

  localparam int CNT_W   = $clog2(2 * SEQ_TCL + 1);
  localparam int DLY_MAX = (DLY_PRESC > DLY_DIRECT) ? DLY_PRESC : DLY_DIRECT;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam logic [CNT_W-1:0] WIN_STD = CNT_W'(SEQ_TCL);
  localparam logic [CNT_W-1:0] WIN_POR = CNT_W'(2 * SEQ_TCL);
  localparam logic [DLY_W-1:0] LAST_P  = DLY_W'(DLY_PRESC - 1);
  localparam logic [DLY_W-1:0] LAST_D  = DLY_W'(DLY_DIRECT - 1);

  phase_e           phase_q;
  rst_kind_e        kind_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DLY_W-1:0] dly_q;
  logic             mode_q;
  logic             bidir_q;

  logic [CNT_W-1:0] win_len;
  logic [DLY_W-1:0] dly_last;
  logic             win_done;

  assign win_len  = (kind_q == RK_POWER_ON) ? WIN_POR : WIN_STD;
  assign dly_last = mode_q ? LAST_D : LAST_P;
  assign win_done = (cnt_q >= win_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      kind_q  <= RK_POWER_ON;
      cnt_q   <= '0;
      dly_q   <= '0;
      mode_q  <= 1'b0;
      bidir_q <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_WAIT;
      kind_q  <= rst_kind_e'(kind_i);
      cnt_q   <= '0;
      dly_q   <= '0;
      mode_q  <= clk_mode_i;
      bidir_q <= bidir_i;
    end else begin
      case (phase_q)
        PH_WAIT: begin
          if (win_done && !ext_rst_i) begin
            phase_q <= PH_DELAY;
            dly_q   <= '0;
          end else if (cnt_q != WIN_POR) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DELAY: begin
          if (dly_q == dly_last) phase_q <= PH_IDLE;
          else                   dly_q   <= dly_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign in_reset_o = (phase_q != PH_IDLE);
  assign hi_open_o  = ((phase_q == PH_WAIT) && win_done) || (phase_q == PH_DELAY);
  assign cap_o      = (phase_q == PH_DELAY) && (dly_q == dly_last);
  assign keep_low_o = ((kind_q == RK_SOFT) || (kind_q == RK_WDOG)) && !bidir_q;

endmodule

// File: rtl/stcap_gate.sv
module stcap_gate
  import stcap_pkg::*;
#(
  parameter int W    = CFG_W,
  parameter int LOWS = LOW_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] held_i,
  input  logic         in_reset_i,
  input  logic         hi_open_i,
  output logic [W-1:0] view_o
);

  logic [W-1:0] open_w;
  logic [W-1:0] masked;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b < LOWS) begin : g_low
      assign open_w[b] = 1'b0;
    end else begin : g_high
      assign open_w[b] = hi_open_i;
    end
  end

  assign masked = (pins_i & open_w) | (held_i & ~open_w);

  always_ff @(posedge clk) begin
    if (rst)             view_o <= '0;
    else if (in_reset_i) view_o <= masked;
    else                 view_o <= pins_i;
  end

endmodule

// File: rtl/stcap_cfg.sv
module stcap_cfg
  import stcap_pkg::*;
#(
  parameter int             W           = CFG_W,
  parameter int             LOWS        = LOW_W,
  parameter logic [W-1:0]   DEFAULT_CFG = 16'hC8E4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_i,
  input  logic         keep_low_i,
  input  logic         single_i,
  input  logic         in_reset_i,
  input  logic [W-1:0] pins_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cfg_o,
  output logic         valid_o
);

  localparam logic [W-1:0] LOW_MASK = W'((1 << LOWS) - 1);
  localparam logic [W-1:0] SAFE_CFG = DEFAULT_CFG & ~LOW_MASK;

  logic         open_q;
  logic [W-1:0] pin_word;

  assign pin_word = keep_low_i ? ((pins_i & ~LOW_MASK) | (cfg_o & LOW_MASK)) : pins_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o   <= '0;
      open_q  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) begin
        if (single_i) begin
          cfg_o  <= SAFE_CFG;
          open_q <= 1'b1;
        end else begin
          cfg_o  <= pin_word;
          open_q <= 1'b0;
        end
      end else if (we_i && open_q && !in_reset_i) begin
        cfg_o  <= wdata_i & ~LOW_MASK;
        open_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/startup_cfg_latch.sv
module startup_cfg_latch
  import stcap_pkg::*;
#(
  parameter int          SEQ_TCL     = 1024,
  parameter int          DLY_PRESC   = 7,
  parameter int          DLY_DIRECT  = 10,
  parameter logic [15:0] DEFAULT_CFG = 16'hC8E4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] pin_i,
  input  logic        ext_rst_i,
  input  logic        rst_start_i,
  input  logic [2:0]  rst_kind_i,
  input  logic        bidir_en_i,
  input  logic        clk_mode_i,
  input  logic        single_chip_i,
  input  logic        cfg_we_i,
  input  logic [15:0] cfg_wdata_i,
  output logic [15:0] cfg_o,
  output logic [2:0]  clk_cfg_o,
  output logic [1:0]  seg_lines_o,
  output logic [1:0]  cs_count_o,
  output logic        wr_cfg_o,
  output logic [1:0]  bus_type_o,
  output logic [3:0]  boot_mode_o,
  output logic        adapt_o,
  output logic        emu_o,
  output logic        cfg_valid_o,
  output logic [15:0] pin_view_o
);

  logic in_reset;
  logic hi_open;
  logic cap_stb;
  logic keep_low;
  cfg_t fields;

  stcap_timer #(
    .SEQ_TCL   (SEQ_TCL),
    .DLY_PRESC (DLY_PRESC),
    .DLY_DIRECT(DLY_DIRECT)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .start_i   (rst_start_i),
    .kind_i    (rst_kind_i),
    .clk_mode_i(clk_mode_i),
    .bidir_i   (bidir_en_i),
    .ext_rst_i (ext_rst_i),
    .in_reset_o(in_reset),
    .hi_open_o (hi_open),
    .cap_o     (cap_stb),
    .keep_low_o(keep_low)
  );

  stcap_gate #(
    .W   (CFG_W),
    .LOWS(LOW_W)
  ) u_gate (
    .clk       (clk),
    .rst       (rst),
    .pins_i    (pin_i),
    .held_i    (cfg_o),
    .in_reset_i(in_reset),
    .hi_open_i (hi_open),
    .view_o    (pin_view_o)
  );

  stcap_cfg #(
    .W          (CFG_W),
    .LOWS       (LOW_W),
    .DEFAULT_CFG(DEFAULT_CFG)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cap_i     (cap_stb),
    .keep_low_i(keep_low),
    .single_i  (single_chip_i),
    .in_reset_i(in_reset),
    .pins_i    (pin_i),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .cfg_o     (cfg_o),
    .valid_o   (cfg_valid_o)
  );

  assign fields      = cfg_t'(cfg_o);
  assign clk_cfg_o   = fields.clk_cfg;
  assign seg_lines_o = fields.seg;
  assign cs_count_o  = fields.cs;
  assign wr_cfg_o    = fields.wr_cfg;
  assign bus_type_o  = fields.bus;
  assign boot_mode_o = fields.boot;
  assign adapt_o     = fields.adapt;
  assign emu_o       = fields.emu;

endmodule

// File: rtl/startup_cfg_latch_chk.sv
module startup_cfg_latch_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_reset,
  input logic        cap,
  input logic        keep_low,
  input logic        single_chip_i,
  input logic        cfg_valid_o,
  input logic [15:0] cfg_o,
  input logic [15:0] pin_view_o
);

  assert_valid_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_valid_o |=> !cfg_valid_o);

  assert_valid_from_reset_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_valid_o |-> $past(in_reset));

  assert_cfg_frozen_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
    (in_reset && !cap) |=> $stable(cfg_o));

  assert_low_pins_masked_R5: assert property (@(posedge clk) disable iff (rst)
    in_reset |=> (pin_view_o[1:0] == $past(cfg_o[1:0])));

  assert_single_chip_no_modes_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid_o && $past(single_chip_i)) |-> (cfg_o[1:0] == 2'b00));

  assert_soft_keeps_low_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid_o && $past(keep_low) && !$past(single_chip_i))
      |-> (cfg_o[1:0] == $past(cfg_o[1:0])));

endmodule

bind startup_cfg_latch startup_cfg_latch_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_reset     (in_reset),
  .cap          (cap_stb),
  .keep_low     (keep_low),
  .single_chip_i(single_chip_i),
  .cfg_valid_o  (cfg_valid_o),
  .cfg_o        (cfg_o),
  .pin_view_o   (pin_view_o)
);

// File: tb/startup_cfg_latch_test.sv
`timescale 1ns/1ps
module startup_cfg_latch_test;

  localparam int          SEQ  = 16;
  localparam int          DP   = 7;
  localparam int          DD   = 10;
  localparam logic [15:0] DEFW = 16'hC8E4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pin_i = 16'h0;
  logic        ext_rst_i = 1'b0;
  logic        rst_start_i = 1'b0;
  logic [2:0]  rst_kind_i = 3'd0;
  logic        bidir_en_i = 1'b0;
  logic        clk_mode_i = 1'b0;
  logic        single_chip_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [15:0] cfg_wdata_i = 16'h0;
  logic [15:0] cfg_o, pin_view_o;
  logic [2:0]  clk_cfg_o;
  logic [1:0]  seg_lines_o, cs_count_o, bus_type_o;
  logic [3:0]  boot_mode_o;
  logic        wr_cfg_o, adapt_o, emu_o, cfg_valid_o;

  int compared = 0;
  int mismatched = 0;
  bit live = 1'b0;

  always #10 clk = ~clk;

  startup_cfg_latch #(.SEQ_TCL(SEQ), .DLY_PRESC(DP), .DLY_DIRECT(DD), .DEFAULT_CFG(DEFW)) uut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .ext_rst_i(ext_rst_i), .rst_start_i(rst_start_i),
    .rst_kind_i(rst_kind_i), .bidir_en_i(bidir_en_i), .clk_mode_i(clk_mode_i),
    .single_chip_i(single_chip_i), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_o(cfg_o), .clk_cfg_o(clk_cfg_o), .seg_lines_o(seg_lines_o), .cs_count_o(cs_count_o),
    .wr_cfg_o(wr_cfg_o), .bus_type_o(bus_type_o), .boot_mode_o(boot_mode_o),
    .adapt_o(adapt_o), .emu_o(emu_o), .cfg_valid_o(cfg_valid_o), .pin_view_o(pin_view_o));

  // behavioural reference
  int          m_phase, m_cnt, m_d, m_kind;
  bit          m_mode, m_bidir, m_open, m_valid;
  logic [15:0] m_cfg, m_view;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cnt = 0; m_d = 0; m_kind = 0; m_mode = 0; m_bidir = 0;
      m_open = 0; m_valid = 0; m_cfg = 16'h0; m_view = 16'h0;
    end else begin
      int  win, dl;
      bit  busy, hopen, cap, keep;
      win   = (m_kind == 0) ? 2 * SEQ : SEQ;
      dl    = m_mode ? DD : DP;
      busy  = (m_phase != 0);
      hopen = (m_phase == 1 && m_cnt >= win) || (m_phase == 2);
      cap   = (m_phase == 2) && (m_d == dl - 1);
      keep  = (m_kind == 3 || m_kind == 4) && !m_bidir;
      if (!busy) m_view = pin_i;
      else m_view = {hopen ? pin_i[15:2] : m_cfg[15:2], m_cfg[1:0]};
      m_valid = cap;
      if (cap) begin
        if (single_chip_i) begin m_cfg = {DEFW[15:2], 2'b00}; m_open = 1; end
        else begin m_cfg = {pin_i[15:2], keep ? m_cfg[1:0] : pin_i[1:0]}; m_open = 0; end
      end else if (cfg_we_i && m_open && !busy) begin
        m_cfg = {cfg_wdata_i[15:2], 2'b00}; m_open = 0;
      end
      if (rst_start_i) begin
        m_phase = 1; m_cnt = 0; m_d = 0; m_kind = int'(rst_kind_i);
        m_mode = clk_mode_i; m_bidir = bidir_en_i;
      end else if (m_phase == 1) begin
        if (m_cnt >= win && !ext_rst_i) begin m_phase = 2; m_d = 0; end
        else m_cnt = m_cnt + 1;
      end else if (m_phase == 2) begin
        if (cap) m_phase = 0; else m_d = m_d + 1;
      end
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R6 cfg vs model", cfg_o, m_cfg);
      chk("R4 view vs model", pin_view_o, m_view);
      chk("R10 valid vs model", {15'h0, cfg_valid_o}, {15'h0, m_valid});
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // start pulse; ext level held as given
  task automatic begin_reset(int kind, bit mode, bit bidir, bit ext);
    rst_start_i = 1'b1; rst_kind_i = 3'(kind); clk_mode_i = mode;
    bidir_en_i = bidir; ext_rst_i = ext;
    tick(1);
    rst_start_i = 1'b0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 200; i++) begin
      if (cfg_valid_o) break;
      tick(1);
    end
  endtask

  task automatic sw_write(logic [15:0] d);
    cfg_we_i = 1'b1; cfg_wdata_i = d;
    tick(1);
    cfg_we_i = 1'b0;
  endtask

  task automatic run_all();
    tick(3);
    rst = 1'b0;
    live = 1'b1;
    // R1 reset state
    chk("R1 cfg after reset", cfg_o, 16'h0);
    chk("R1 valid after reset", {15'h0, cfg_valid_o}, 16'h0);
    chk("R1 view after reset", pin_view_o, 16'h0);

    // power-on, long, prescaler
    pin_i = 16'hA5C3;
    begin_reset(0, 1'b0, 1'b0, 1'b1);
    tick(20);
    chk("R4 power-on window still masked", pin_view_o, 16'h0000);
    tick(19);
    chk("R4 upper pins open after window", {pin_view_o[15:2], 2'b00}, 16'hA5C0);
    chk("R5 low pins masked", {14'h0, pin_view_o[1:0]}, 16'h0);
    ext_rst_i = 1'b0;
    tick(DP);
    chk("R2 R3 no capture before prescaler delay", {15'h0, cfg_valid_o}, 16'h0);
    tick(1);
    chk("R2 R3 capture after long release + 7", {15'h0, cfg_valid_o}, 16'h1);
    chk("R6 captured word", cfg_o, 16'hA5C3);
    chk("R6 field decode", {clk_cfg_o, seg_lines_o, cs_count_o, wr_cfg_o, bus_type_o,
                             boot_mode_o, adapt_o, emu_o}, 16'hA5C3);
    chk("R6 clock field", {13'h0, clk_cfg_o}, 16'h0005);
    tick(1);
    chk("R10 valid drops", {15'h0, cfg_valid_o}, 16'h0);

    // short hardware, direct mode
    pin_i = 16'h3C5A;
    begin_reset(2, 1'b1, 1'b0, 1'b1);
    tick(2);
    ext_rst_i = 1'b0;
    tick(SEQ + DD - 2);
    chk("R3 short reset waits for window", {15'h0, cfg_valid_o}, 16'h0);
    tick(1);
    chk("R2 R3 short capture window + 10", {15'h0, cfg_valid_o}, 16'h1);
    chk("R6 short captured word", cfg_o, 16'h3C5A);

    // software reset, no bidir: low bits kept
    pin_i = 16'hFFFF;
    begin_reset(3, 1'b0, 1'b0, 1'b0);
    tick(SEQ + 3);
    chk("R5 view low bits held", pin_view_o, 16'hFFFE);
    wait_valid();
    chk("R7 software keeps low bits", cfg_o, 16'hFFFE);

    // watchdog with bidir: low bits recaptured
    pin_i = 16'h0001;
    begin_reset(4, 1'b0, 1'b1, 1'b0);
    wait_valid();
    chk("R7 watchdog bidir recaptures", cfg_o, 16'h0001);
    tick(2);
    sw_write(16'hFFFF);
    chk("R9 write after pin capture ignored", cfg_o, 16'h0001);

    // single chip
    pin_i = 16'h1234; single_chip_i = 1'b1;
    begin_reset(1, 1'b0, 1'b0, 1'b1);
    tick(SEQ + 2);
    ext_rst_i = 1'b0;
    wait_valid();
    chk("R8 default loaded", cfg_o, {DEFW[15:2], 2'b00});
    single_chip_i = 1'b0;
    tick(1);
    sw_write(16'h5A5B);
    chk("R9 first write taken, modes cleared", cfg_o, 16'h5A58);
    sw_write(16'h0F0F);
    chk("R9 second write ignored", cfg_o, 16'h5A58);

    // write during reset ignored
    single_chip_i = 1'b1;
    begin_reset(2, 1'b0, 1'b0, 1'b0);
    wait_valid();
    single_chip_i = 1'b0;
    pin_i = 16'h8003;
    begin_reset(3, 1'b0, 1'b0, 1'b0);
    tick(2);
    sw_write(16'h1111);
    chk("R9 write in reset ignored", cfg_o, {DEFW[15:2], 2'b00});
    wait_valid();
    chk("R7 keep low after default", cfg_o, 16'h8000);

    // restart
    pin_i = 16'h4242;
    begin_reset(2, 1'b0, 1'b1, 1'b0);
    tick(7);
    begin_reset(2, 1'b0, 1'b1, 1'b0);
    tick(SEQ + DP);
    chk("R11 restart delays capture", {15'h0, cfg_valid_o}, 16'h0);
    tick(1);
    chk("R11 capture counted from restart", {15'h0, cfg_valid_o}, 16'h1);
    chk("R11 restarted word", cfg_o, 16'h4242);
    pin_i = 16'h7777;
    tick(2);
    chk("R4 view follows pins outside reset", pin_view_o, 16'h7777);
    tick(2);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule